// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Bank

This block gathers single-cycle event pulses from the parts of an SPI controller (shifter, transmit and receive FIFOs, mode-fault detector) and turns them into one level-sensitive interrupt request. Each event lands in a sticky status bit that stays set until software clears it by writing a one to it. Whether a status bit can raise the interrupt depends on a mask bit. Software never writes the mask directly. One write-only location turns mask bits on, another turns them off, and a read-only location returns the mask.

All four locations use the same bit layout over seven event bits (6:0). Bit 1 is mode fault, bit 2 is transmit FIFO below its threshold, bit 3 is transmit FIFO full, and bit 4 is receive FIFO holding data. Bits 0, 5 and 6 are further event sources with the same treatment. The register port is a plain strobe interface: address, write data, write strobe and read strobe. Read data is registered and appears one clock after the read strobe.

Top module: `spi_irq_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all status bits and all mask bits are 0, irq_o is 0 and reg_rdata_o is 0.
- R2: An event pulse on evt_i[n] sets status bit n at the next clock edge, whatever the mask holds. The bit stays set until it is cleared.
- R3: A write to offset 0x04 (status) clears exactly those status bits whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: If an event pulse and a status write with a one target the same bit in the same cycle, the bit is set after that edge.
- R5: A write to offset 0x08 (mask-set) sets each mask bit whose write-data bit is 1. The other mask bits keep their value.
- R6: A write to offset 0x0C (mask-clear) clears each mask bit whose write-data bit is 1. The other mask bits keep their value.
- R7: The mask changes only through offsets 0x08 and 0x0C. A write to offset 0x10 (mask view), to the status offset or to any other offset leaves it unchanged.
- R8: irq_o is 1 exactly when at least one status bit and its mask bit are both 1. irq_o follows the registers with no further delay.
- R9: Reading offset 0x04 returns the status bits on 6:0, and reading offset 0x10 returns the mask bits on 6:0. Bits above 6 always read 0. Reads of 0x08, 0x0C and any unmapped offset return 0. Write-data bits above 6 have no effect.
- R10: reg_rdata_o loads at the clock edge that samples reg_rd_i high, using the register values from before that edge. It holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr_i | input | ADDR_W (6) | Byte offset of the register access |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_rd_i | input | 1 | Read strobe, one cycle per read |
| evt_i | input | N_EVT (7) | Event pulses, one bit per source |
| reg_rdata_o | output | DATA_W (32) | Registered read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The embedded properties assume that the write and read strobes are only high while rst_n is high, and that the inputs are held at zero during reset, so every past value the properties see after reset is defined. They also assume that one access has exactly one address, so the set and clear paths of the mask can never be hit in the same cycle. The stimulus drives all inputs at the falling edge and keeps them at zero throughout reset. It pairs a directed sequence that forces each corner (event racing a clear, zero-bit writes, writes to the read-only view, wide write data) with a randomized run of events, writes and reads over every mapped offset and two unmapped ones.

// File: rtl/spi_irq_pkg.sv
// Shared constants and types of the SPI interrupt bank.
// Offsets are byte addresses that software decodes; they must not move.
package spi_irq_pkg;

    localparam int OFS_STATUS   = 'h04;  // sticky status, write one to clear
    localparam int OFS_MSK_SET  = 'h08;  // write-only, ones set mask bits
    localparam int OFS_MSK_CLR  = 'h0C;  // write-only, ones clear mask bits
    localparam int OFS_MSK_VIEW = 'h10;  // read-only mask view

    typedef enum logic [1:0] {
        RSEL_ZERO   = 2'd0,
        RSEL_STATUS = 2'd1,
        RSEL_MASK   = 2'd2
    } rsel_e;

endpackage

// File: rtl/spi_irq_decode.sv
// Address decode of the interrupt bank.
// Turns one register access into per-bit clear and set vectors and a read
// selector. Assumes one access carries one address, so the status clear,
// mask set and mask clear vectors are never non-zero together.
module spi_irq_decode
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int N_EVT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    output logic [N_EVT-1:0]  sts_clr_o,
    output logic [N_EVT-1:0]  msk_set_o,
    output logic [N_EVT-1:0]  msk_clr_o,
    output rsel_e             rsel_o
);

    logic hit_sts, hit_set, hit_clr, hit_view;
    logic [N_EVT-1:0] wbits;
    logic unused_wdata_hi;

    // Compare the offset against every mapped location.
    always_comb begin
        hit_sts  = (addr_i == ADDR_W'(OFS_STATUS));
        hit_set  = (addr_i == ADDR_W'(OFS_MSK_SET));
        hit_clr  = (addr_i == ADDR_W'(OFS_MSK_CLR));
        hit_view = (addr_i == ADDR_W'(OFS_MSK_VIEW));
    end

    assign wbits           = wdata_i[N_EVT-1:0];
    assign unused_wdata_hi = ^wdata_i[DATA_W-1:N_EVT];

    // Steer the write bits to the one register they address.
    always_comb begin
        sts_clr_o = (wr_i && hit_sts) ? wbits : '0;
        msk_set_o = (wr_i && hit_set) ? wbits : '0;
        msk_clr_o = (wr_i && hit_clr) ? wbits : '0;
    end

    // Pick the read source; write-only and unmapped offsets read as zero.
    always_comb begin
        if (hit_sts)       rsel_o = RSEL_STATUS;
        else if (hit_view) rsel_o = RSEL_MASK;
        else               rsel_o = RSEL_ZERO;
    end

    // R7: at most one register is targeted by a single write
    p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|sts_clr_o, |msk_set_o, |msk_clr_o}));

endmodule

// File: rtl/spi_irq_status.sv
// Sticky event status register.
// Each bit is set by an event pulse and cleared by a write-one-to-clear.
// An event in the same cycle as a clear of the same bit wins.
module spi_irq_status #(
    parameter int N_EVT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] evt_i,
    input  logic [N_EVT-1:0] clr_i,
    output logic [N_EVT-1:0] sts_o
);

    genvar b;
    generate
        for (b = 0; b < N_EVT; b++) begin : g_cell
            logic cell_q;
            // One sticky cell: set by its event, dropped by its clear bit.
            always_ff @(posedge clk) begin
                if (!rst_n)         cell_q <= 1'b0;
                else if (evt_i[b])  cell_q <= 1'b1;
                else if (clr_i[b])  cell_q <= 1'b0;
            end
            assign sts_o[b] = cell_q;
        end
    endgenerate

    // R2: a set bit with no clear request stays set
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sts_o) & ~$past(clr_i)) & ~sts_o) == '0);

    // R2, R4: every pulsed bit is set on the next edge, clear or not
    p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_i) & ~sts_o) == '0);

    // R3: a cleared bit with no racing event reads zero afterwards
    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clr_i) & ~$past(evt_i)) & sts_o) == '0);

endmodule

// File: rtl/spi_irq_mask.sv
// Interrupt enable mask, written only through separate set and clear vectors.
// Assumes set and clear never carry ones in the same cycle.
module spi_irq_mask #(
    parameter int N_EVT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] set_i,
    input  logic [N_EVT-1:0] clr_i,
    output logic [N_EVT-1:0] msk_o
);

    logic [N_EVT-1:0] msk_q;

    // Apply set ones and clear ones; zero bits keep their value.
    always_ff @(posedge clk) begin
        if (!rst_n) msk_q <= '0;
        else        msk_q <= (msk_q & ~clr_i) | set_i;
    end

    assign msk_o = msk_q;

    // R5: each set bit reads one after the edge
    p_set_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_i) & ~msk_q) == '0);

    // R6: each cleared bit reads zero after the edge
    p_clr_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_i) & msk_q) == '0);

    // R7: without a set or clear request the mask holds
    p_mask_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(|set_i) && !$past(|clr_i)) |-> $stable(msk_q));

endmodule

// File: rtl/spi_irq_rdmux.sv
// Registered read path of the interrupt bank.
// Loads on a read strobe from the selected source, zero-extended to the bus
// width, and holds otherwise. Assumes DATA_W >= N_EVT.
module spi_irq_rdmux
    import spi_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_EVT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  rsel_e             rsel_i,
    input  logic [N_EVT-1:0]  sts_i,
    input  logic [N_EVT-1:0]  msk_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [N_EVT-1:0] pick;

    // Choose the source word for the current offset.
    always_comb begin
        case (rsel_i)
            RSEL_STATUS: pick = sts_i;
            RSEL_MASK:   pick = msk_i;
            default:     pick = '0;
        endcase
    end

    // Capture on a read strobe, hold between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= DATA_W'(pick);
    end

    // R10: read data does not move without a read strobe
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_i) |-> $stable(rdata_o));

    // R9: a read of a zero-reading offset returns zero
    p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_i) && $past(rsel_i) == RSEL_ZERO) |-> (rdata_o == '0));

    // R9: bits above the event field always read zero
    p_rd_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_o >> N_EVT) == '0);

endmodule

// File: rtl/spi_irq_bank.sv
// SPI controller interrupt bank: sticky status, set/clear mask, level IRQ.
// Assumes event pulses come from logic on the same clock and that register
// strobes are low while rst_n is low.
module spi_irq_bank
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int N_EVT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [N_EVT-1:0]  evt_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    logic [N_EVT-1:0] sts_clr, msk_set, msk_clr;
    logic [N_EVT-1:0] sts, msk;
    rsel_e            rsel;

    spi_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EVT(N_EVT)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .wr_i      (reg_wr_i),
        .sts_clr_o (sts_clr),
        .msk_set_o (msk_set),
        .msk_clr_o (msk_clr),
        .rsel_o    (rsel)
    );

    spi_irq_status #(.N_EVT(N_EVT)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .clr_i (sts_clr),
        .sts_o (sts)
    );

    spi_irq_mask #(.N_EVT(N_EVT)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (msk_set),
        .clr_i (msk_clr),
        .msk_o (msk)
    );

    spi_irq_rdmux #(.DATA_W(DATA_W), .N_EVT(N_EVT)) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (reg_rd_i),
        .rsel_i  (rsel),
        .sts_i   (sts),
        .msk_i   (msk),
        .rdata_o (reg_rdata_o)
    );

    // Gate each status bit by its mask bit and merge into one level.
    assign irq_o = |(sts & msk);

    // R1: the cycle after reset the outputs are quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_o && reg_rdata_o == '0));

    // R8: the request only rises after an event or a register write
    p_irq_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(|evt_i) || $past(reg_wr_i)));

endmodule

// File: tb/spi_irq_bank_tb.sv
module spi_irq_bank_tb;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int N_EVT  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [N_EVT-1:0]  evt = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int total = 0;
    int bad   = 0;
    bit run_cmp = 1'b0;
    bit done    = 1'b0;

    // reference model state
    int m_sts = 0;
    int m_msk = 0;
    int m_rd  = 0;

    always #2 clk = ~clk;

    spi_irq_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_EVT(N_EVT)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .evt_i       (evt),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model of the register bank, updated at each rising edge
    always @(posedge clk) begin
        int a;
        int nrd;
        a = int'(reg_addr);
        if (!rst_n) begin
            m_sts = 0; m_msk = 0; m_rd = 0;
        end else begin
            nrd = m_rd;
            if (reg_rd) begin
                if (a == 4)       nrd = m_sts;
                else if (a == 16) nrd = m_msk;
                else              nrd = 0;
            end
            if (reg_wr) begin
                if (a == 4)  m_sts = m_sts & ~(int'(reg_wdata) & 'h7F);
                if (a == 8)  m_msk = m_msk | (int'(reg_wdata) & 'h7F);
                if (a == 12) m_msk = m_msk & ~(int'(reg_wdata) & 'h7F);
            end
            m_sts = m_sts | int'(evt);
            m_rd  = nrd;
        end
    end

    // compare outputs against the model on every falling edge
    always @(negedge clk) begin
        if (run_cmp && !done) begin
            check("R8 irq level", int'(irq), ((m_sts & m_msk) != 0) ? 1 : 0);
            check("R9/R10 read data", int'(reg_rdata), m_rd);
        end
    end

    // one access cycle, driven at a falling edge; returns at the next one
    task automatic cyc(input bit wr, input bit rd, input int addr,
                       input int wdata, input int ev);
        reg_wr    = wr;
        reg_rd    = rd;
        reg_addr  = ADDR_W'(addr);
        reg_wdata = DATA_W'(wdata);
        evt       = N_EVT'(ev);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; evt = '0;
    endtask

    task automatic rd_reg(input int addr, output int v);
        cyc(1'b0, 1'b1, addr, 0, 0);
        v = int'(reg_rdata);
    endtask

    task automatic wr_reg(input int addr, input int data);
        cyc(1'b1, 1'b0, addr, data, 0);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_cmp = 1'b1;

        // R1: quiet after reset
        check("R1 irq after reset", int'(irq), 0);
        check("R1 rdata after reset", int'(reg_rdata), 0);
        rd_reg('h04, v); check("R1 status after reset", v, 0);
        rd_reg('h10, v); check("R1 mask after reset", v, 0);

        // R2: event latches with mask off, no irq
        cyc(1'b0, 1'b0, 0, 0, 'h02);
        check("R2 irq masked", int'(irq), 0);
        rd_reg('h04, v); check("R2 status latched", v, 'h02);
        repeat (3) cyc(1'b0, 1'b0, 0, 0, 0);
        rd_reg('h04, v); check("R2 status sticky", v, 'h02);

        // R3: write-one-to-clear
        wr_reg('h04, 'h00);
        rd_reg('h04, v); check("R3 zero write keeps", v, 'h02);
        wr_reg('h04, 'h7D);
        rd_reg('h04, v); check("R3 other ones keep", v, 'h02);
        wr_reg('h04, 'h02);
        rd_reg('h04, v); check("R3 clear bit", v, 'h00);

        // R4: event and clear race on bit 3
        cyc(1'b1, 1'b0, 'h04, 'h08, 'h08);
        rd_reg('h04, v); check("R4 event wins", v, 'h08);

        // R5: set mask bits
        wr_reg('h08, 'h14);
        rd_reg('h10, v); check("R5 mask set", v, 'h14);
        check("R8 no overlap no irq", int'(irq), 0);
        cyc(1'b0, 1'b0, 0, 0, 'h10);
        check("R8 irq raised", int'(irq), 1);
        wr_reg('h08, 'h00);
        rd_reg('h10, v); check("R5 zero write keeps", v, 'h14);

        // R6: clear mask bits
        wr_reg('h0C, 'h04);
        rd_reg('h10, v); check("R6 mask clear", v, 'h10);
        wr_reg('h0C, 'h10);
        check("R8 irq drops on mask clear", int'(irq), 0);
        rd_reg('h10, v); check("R6 mask empty", v, 'h00);
        wr_reg('h08, 'h10);
        check("R8 irq back on mask set", int'(irq), 1);

        // R7: mask view and status writes leave the mask alone
        wr_reg('h10, 'h7F);
        rd_reg('h10, v); check("R7 view write ignored", v, 'h10);
        wr_reg('h04, 'h7F);
        rd_reg('h10, v); check("R7 status write keeps mask", v, 'h10);
        check("R8 irq drops on status clear", int'(irq), 0);
        wr_reg('h14, 'h7F);
        rd_reg('h10, v); check("R7 unmapped write keeps mask", v, 'h10);

        // R9: zero-reading offsets and wide data
        rd_reg('h08, v); check("R9 set offset reads zero", v, 0);
        rd_reg('h0C, v); check("R9 clear offset reads zero", v, 0);
        rd_reg('h00, v); check("R9 unmapped reads zero", v, 0);
        wr_reg('h08, 32'hFFFF_FF00);
        rd_reg('h10, v); check("R9 upper write bits ignored", v, 'h10);

        // R10: read data holds until the next read
        rd_reg('h04, v); check("R10 status before event", v, 0);
        cyc(1'b0, 1'b0, 0, 0, 'h01);
        check("R10 hold without read", int'(reg_rdata), 0);
        rd_reg('h04, v); check("R10 fresh read", v, 'h01);

        // random mix, compared against the model every cycle
        for (int i = 0; i < 600; i++) begin
            int k;
            int ev;
            k  = $urandom_range(0, 5);
            ev = ($urandom_range(0, 3) == 0) ? int'($urandom & 'h7F) : 0;
            cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
                k * 4, int'($urandom), ev);
        end

        run_cmp = 1'b0;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule